// File: doc/BRIEF.md
# Segment column data loader

This block fills one display line of column bits for a segment-type matrix display driver that can be chained with other drivers of the same kind. Pixel data arrives on a parallel bus that is either 4 or 8 bits wide. A slow shift clock strobes the bus. The shift clock and the latch pulse are both sampled on the system clock and act on their falling edges. Several loaders share one bus, and they take turns through a daisy-chained enable. A loader is armed by a latch pulse. Once armed, it waits for its enable input to go low and then collects a full line of `NUM_COLS` bits. After the last bit it drops its enable output for exactly one shift-clock period, which selects the next device in the chain, and then it ignores the bus.

The next falling edge of the latch pulse copies the whole loaded line into a line latch in one step. Each column of the line latch then gets a 2-bit level code. The code is chosen from the latched bit, the frame-inversion input and the display-enable input. A direction input mirrors the order in which bus bits are placed into columns. It also swaps which of the two enable ports is the input and which is the output.

Top module: `seg_line_loader`

## Requirements
- R1: After reset the line latch and the data store are clear, no data is accepted until a latch-pulse falling edge, and both enable outputs are high.
- R2: With `wide_mode`=1 a line takes 20 shift-clock falling edges of 8 bits each. With `dir_up`=0, bit j of word k (k from 0) lands in column 153-8k+j, where columns are numbered 1..160.
- R3: With `wide_mode`=0 a line takes 40 shift-clock falling edges of 4 bits (`data_in[3:0]`). With `dir_up`=0, bit j of nibble n lands in column 157-4n+j. `data_in[7:4]` is ignored in this mode.
- R4: With `dir_up`=1 the placement is mirrored. In 8-bit mode, bit j of word k lands in column 8k+8-j. In 4-bit mode, bit j of nibble n lands in column 4n+4-j.
- R5: The enable output port (`eio_a_out` when `dir_up`=0, `eio_b_out` when `dir_up`=1) goes low at the shift-clock falling edge that completes the line. It returns high at the next shift-clock falling edge. The other enable output port stays high.
- R6: After a latch-pulse falling edge, shift-clock edges are ignored while the enable input port (`eio_b_in` when `dir_up`=0, `eio_a_in` when `dir_up`=1) is high. The first edge that sees it low is taken as data.
- R7: Once a line is complete, further shift-clock edges are ignored until the next latch-pulse falling edge.
- R8: A latch-pulse falling edge copies all loaded columns into the line latch at once. Between such edges the line latch does not change while the display is enabled.
- R9: Level code per column, with the display enabled: frame 0 and bit 0 give 1; frame 0 and bit 1 give 0; frame 1 and bit 0 give 2; frame 1 and bit 1 give 3. Column c (1-based) occupies `lvl_code[2c-1:2c-2]`.
- R10: While `disp_on`=0, every code is 0 and the line latch is cleared, but loading of the data store continues. After release, every code shows the data-0 level until the next latch-pulse falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Data strobe; acts on its falling edge |
| latch_pulse | input | 1 | Line transfer strobe; acts on its falling edge |
| wide_mode | input | 1 | 1 selects 8-bit words, 0 selects 4-bit nibbles |
| dir_up | input | 1 | Placement direction and enable port roles |
| data_in | input | 8 | Pixel data bus |
| frame_inv | input | 1 | Frame inversion select |
| disp_on | input | 1 | Display enable; 0 forces the lowest level |
| eio_a_in | input | 1 | Enable input when `dir_up`=1 |
| eio_b_in | input | 1 | Enable input when `dir_up`=0 |
| eio_a_out | output | 1 | Enable output when `dir_up`=0, otherwise held high |
| eio_b_out | output | 1 | Enable output when `dir_up`=1, otherwise held high |
| lvl_code | output | 2*NUM_COLS | Per-column 2-bit level codes |

## Verification
On every cycle, the assertions check four things. The word counter never passes the last word of a line. The enable output falls only right after a detected shift-clock edge, and it stays low for exactly one shift period. The codes stay fixed between latch-pulse edges while the display is enabled. Every code shows the deselect level on the cycle the display is released.

Only the bench scenarios can show where each bus bit lands, and only they show that edges are ignored before selection and after completion. The same holds for the full truth table and for loading that continues while the display is off. The bench covers both bus widths in both directions, and it checks every column against a model built from the placement formulas.

// File: rtl/seg_ld_pkg.sv
// Shared level encoding and column code function for the segment line loader.
package seg_ld_pkg;

    typedef enum logic [1:0] {
        LVL_LOWEST  = 2'd0,
        LVL_LOWMID  = 2'd1,
        LVL_HIGHMID = 2'd2,
        LVL_HIGHEST = 2'd3
    } lvl_t;

    // Map display enable, frame phase and latched bit to a level code.
    function automatic lvl_t level_of(input logic on, input logic frame, input logic bit_v);
        if (!on)
            return LVL_LOWEST;
        else if (!frame)
            return bit_v ? LVL_LOWEST : LVL_LOWMID;
        else
            return bit_v ? LVL_HIGHEST : LVL_HIGHMID;
    endfunction

endpackage

// File: rtl/seg_ld_fall.sv
// Falling-edge detector for a slow strobe sampled on the system clock.
// Assumes the strobe stays in each level for at least SYNC_STAGES+1 clocks.
module seg_ld_fall #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronise the strobe and keep its previous settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], strobe};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/seg_ld_ctrl.sv
// Selection and word sequencing: arms on a latch edge, waits for the chain
// enable, packs nibble pairs into bytes, counts words and emits the one-period
// enable-out pulse. Assumes both edge strobes are single-cycle pulses.
module seg_ld_ctrl #(
    parameter int WORDS = 20,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_fall,
    input  logic             lp_fall,
    input  logic             wide_mode,
    input  logic             en_in,
    input  logic [7:0]       data_in,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_byte,
    output logic             en_low
);
    typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_LOAD} st_t;

    st_t        st_q;
    logic       half_q;
    logic [3:0] hold_q;
    logic       take;
    logic       word_done;

    // Decide whether this strobe edge is accepted and whether it finishes a byte.
    always_comb begin
        take      = sclk_fall && !lp_fall &&
                    ((st_q == ST_LOAD) || (st_q == ST_ARMED && !en_in));
        word_done = take && (wide_mode || half_q);
        wr_en     = word_done;
        wr_byte   = wide_mode ? data_in : {hold_q, data_in[3:0]};
    end

    // Sequence state, word index, nibble holding and enable-out pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            wr_idx <= '0;
            half_q <= 1'b0;
            hold_q <= '0;
            en_low <= 1'b0;
        end else begin
            if (sclk_fall)
                en_low <= 1'b0;
            if (lp_fall) begin
                st_q   <= ST_ARMED;
                wr_idx <= '0;
                half_q <= 1'b0;
            end else if (word_done) begin
                half_q <= 1'b0;
                if (wr_idx == IDX_W'(WORDS - 1)) begin
                    st_q   <= ST_IDLE;
                    wr_idx <= '0;
                    en_low <= 1'b1;
                end else begin
                    st_q   <= ST_LOAD;
                    wr_idx <= wr_idx + 1'b1;
                end
            end else if (take) begin
                hold_q <= data_in[3:0];
                half_q <= 1'b1;
                st_q   <= ST_LOAD;
            end
        end
    end
endmodule

// File: rtl/seg_ld_store.sv
// Column data store and line latch. Places each byte at a direction-dependent
// column base; copies to the line latch on a latch edge; clears the latch
// while the display is off. Assumes NUM_COLS is a multiple of 8.
module seg_ld_store #(
    parameter int NUM_COLS = 160,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [7:0]          wr_byte,
    input  logic                dir_up,
    input  logic                lp_fall,
    input  logic                disp_on,
    output logic [NUM_COLS-1:0] line_bits
);
    localparam int COL_W = $clog2(NUM_COLS);
    localparam int TOP   = NUM_COLS - 8;

    logic [NUM_COLS-1:0] store_q;
    logic [COL_W-1:0]    wr_base;
    logic [7:0]          wr_bits;

    // Column base and bit order for the incoming byte.
    always_comb begin
        if (dir_up) begin
            wr_base = COL_W'(int'(wr_idx) * 8);
            for (int i = 0; i < 8; i++)
                wr_bits[i] = wr_byte[7-i];
        end else begin
            wr_base = COL_W'(TOP - int'(wr_idx) * 8);
            wr_bits = wr_byte;
        end
    end

    // Data store write; runs regardless of display enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (wr_en)
            store_q[wr_base +: 8] <= wr_bits;
    end

    // Line latch: cleared while display is off, loaded on a latch edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_bits <= '0;
        else if (!disp_on)
            line_bits <= '0;
        else if (lp_fall)
            line_bits <= store_q;
    end
endmodule

// File: rtl/seg_ld_levels.sv
// Per-column level encoder from latched bit, frame phase and display enable.
module seg_ld_levels
    import seg_ld_pkg::*;
#(
    parameter int NUM_COLS = 160
) (
    input  logic [NUM_COLS-1:0]   line_bits,
    input  logic                  frame_inv,
    input  logic                  disp_on,
    output logic [2*NUM_COLS-1:0] lvl_code
);
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        assign lvl_code[2*c +: 2] = level_of(disp_on, frame_inv, line_bits[c]);
    end
endmodule

// File: rtl/seg_line_loader.sv
// Top of the segment line loader: edge detection, sequencing, storage and
// level encoding. Assumes strobes are slow relative to clk.
module seg_line_loader #(
    parameter int NUM_COLS    = 160,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_clk,
    input  logic                  latch_pulse,
    input  logic                  wide_mode,
    input  logic                  dir_up,
    input  logic [7:0]            data_in,
    input  logic                  frame_inv,
    input  logic                  disp_on,
    input  logic                  eio_a_in,
    input  logic                  eio_b_in,
    output logic                  eio_a_out,
    output logic                  eio_b_out,
    output logic [2*NUM_COLS-1:0] lvl_code
);
    localparam int WORDS = NUM_COLS / 8;
    localparam int IDX_W = $clog2(WORDS);

    logic                sclk_fall;
    logic                lp_fall;
    logic                en_in;
    logic                en_low;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx;
    logic [7:0]          wr_byte;
    logic [NUM_COLS-1:0] line_bits;

    seg_ld_fall #(.SYNC_STAGES(SYNC_STAGES)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .strobe(shift_clk), .fall(sclk_fall));

    seg_ld_fall #(.SYNC_STAGES(SYNC_STAGES)) u_lp_edge (
        .clk(clk), .rst_n(rst_n), .strobe(latch_pulse), .fall(lp_fall));

    assign en_in     = dir_up ? eio_a_in : eio_b_in;
    assign eio_a_out = dir_up ? 1'b1 : ~en_low;
    assign eio_b_out = dir_up ? ~en_low : 1'b1;

    seg_ld_ctrl #(.WORDS(WORDS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .lp_fall(lp_fall),
        .wide_mode(wide_mode), .en_in(en_in), .data_in(data_in),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .en_low(en_low));

    seg_ld_store #(.NUM_COLS(NUM_COLS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_byte(wr_byte), .dir_up(dir_up), .lp_fall(lp_fall),
        .disp_on(disp_on), .line_bits(line_bits));

    seg_ld_levels #(.NUM_COLS(NUM_COLS)) u_levels (
        .line_bits(line_bits), .frame_inv(frame_inv), .disp_on(disp_on),
        .lvl_code(lvl_code));
endmodule

// File: rtl/seg_line_loader_chk.sv
// Assertion checker for the segment line loader, bound into the top module.
module seg_line_loader_chk #(
    parameter int NUM_COLS = 160,
    parameter int WORDS    = 20,
    parameter int IDX_W    = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sclk_fall,
    input logic                  lp_fall,
    input logic [IDX_W-1:0]      wr_idx,
    input logic                  disp_on,
    input logic                  frame_inv,
    input logic                  dir_up,
    input logic                  eio_a_out,
    input logic                  eio_b_out,
    input logic [2*NUM_COLS-1:0] lvl_code
);
    logic en_out;
    assign en_out = dir_up ? eio_b_out : eio_a_out;

    // R2: word index never passes the last word of the line.
    p_word_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_idx) < WORDS);

    // R5: the enable output falls only after a detected shift edge.
    p_en_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en_out) && $stable(dir_up)) |-> $past(sclk_fall));

    // R5: a low enable output returns high at the next shift edge.
    p_en_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_out && sclk_fall && !lp_fall) |=> (en_out || !$stable(dir_up)));

    // R8: codes hold between latch edges while the display stays enabled.
    p_codes_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(frame_inv) && disp_on && $past(disp_on) && !$past(lp_fall))
        |-> $stable(lvl_code));

    // R10: on release from display-off all columns show the data-0 level.
    p_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!disp_on) && disp_on)
        |-> (lvl_code == {NUM_COLS{frame_inv ? 2'b10 : 2'b01}}));
endmodule

bind seg_line_loader seg_line_loader_chk #(
    .NUM_COLS(NUM_COLS), .WORDS(WORDS), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .lp_fall(lp_fall),
    .wr_idx(wr_idx), .disp_on(disp_on), .frame_inv(frame_inv),
    .dir_up(dir_up), .eio_a_out(eio_a_out), .eio_b_out(eio_b_out),
    .lvl_code(lvl_code));

// File: tb/seg_line_loader_tb.sv
// Self-checking bench: loads lines in both bus widths and both directions,
// and compares every column code against a model built from the placement rules.
module seg_line_loader_tb;
    localparam int NC = 160;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shift_clk = 1'b0;
    logic          latch_pulse = 1'b0;
    logic          wide_mode = 1'b1;
    logic          dir_up = 1'b0;
    logic [7:0]    data_in = '0;
    logic          frame_inv = 1'b0;
    logic          disp_on = 1'b1;
    logic          eio_a_in = 1'b1;
    logic          eio_b_in = 1'b1;
    logic          eio_a_out;
    logic          eio_b_out;
    logic [2*NC-1:0] lvl_code;

    int n_tests = 0;
    int n_fail  = 0;
    logic [NC-1:0] tgt;
    logic [NC-1:0] shown;

    always #5 clk = ~clk;

    seg_line_loader u_dut (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .latch_pulse(latch_pulse),
        .wide_mode(wide_mode), .dir_up(dir_up), .data_in(data_in),
        .frame_inv(frame_inv), .disp_on(disp_on), .eio_a_in(eio_a_in),
        .eio_b_in(eio_b_in), .eio_a_out(eio_a_out), .eio_b_out(eio_b_out),
        .lvl_code(lvl_code));

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check1(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Compare all codes against the R9/R10 table applied to a bit vector.
    task automatic check_codes(input string req, input logic [NC-1:0] bits);
        logic [2*NC-1:0] exp;
        for (int c = 0; c < NC; c++) begin
            if (!disp_on)        exp[2*c +: 2] = 2'd0;
            else if (!frame_inv) exp[2*c +: 2] = bits[c] ? 2'd0 : 2'd1;
            else                 exp[2*c +: 2] = bits[c] ? 2'd3 : 2'd2;
        end
        n_tests++;
        if (lvl_code !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, lvl_code, exp);
        end
    endtask

    task automatic shift(input logic [7:0] d);
        @(negedge clk);
        data_in = d;
        shift_clk = 1'b1;
        repeat (5) @(negedge clk);
        shift_clk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic latch();
        @(negedge clk);
        latch_pulse = 1'b1;
        repeat (5) @(negedge clk);
        latch_pulse = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic make_tgt(input int seed);
        for (int c = 0; c < NC; c++)
            tgt[c] = (((c * seed + c / 3 + seed) % 7) < 3);
    endtask

    // Send a whole line per R2/R3/R4 placement; check the R5 pulse around the end.
    task automatic load_line(input logic w, input logic d);
        int   steps;
        logic [7:0] v;
        steps = w ? NC / 8 : NC / 4;
        wide_mode = w;
        dir_up = d;
        for (int s = 0; s < steps; s++) begin
            v = w ? 8'h00 : 8'hA0;   // upper nibble is junk in 4-bit mode (R3)
            for (int j = 0; j < (w ? 8 : 4); j++) begin
                if (w) v[j] = d ? tgt[8*s + 7 - j] : tgt[NC - 8 - 8*s + j];
                else   v[j] = d ? tgt[4*s + 3 - j] : tgt[NC - 4 - 4*s + j];
            end
            if (s == steps - 1)
                check1("R5 enable out high before last word", d ? eio_b_out : eio_a_out, 1'b1);
            shift(v);
        end
        check1("R5 enable out low after line", d ? eio_b_out : eio_a_out, 1'b0);
        check1("R5 other enable port high", d ? eio_a_out : eio_b_out, 1'b1);
        shift(8'hFF);   // R7: ignored
        check1("R5 enable out back high", d ? eio_b_out : eio_a_out, 1'b1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        shown = '0;
        check_codes("R1 reset codes", shown);
        check1("R1 eio_a_out idle", eio_a_out, 1'b1);
        check1("R1 eio_b_out idle", eio_b_out, 1'b1);
        eio_a_in = 1'b0; eio_b_in = 1'b0;
        shift(8'hFF);
        latch();
        check_codes("R1 no data taken before latch edge", shown);

        // R2: 8-bit, dir low
        make_tgt(3);
        latch();
        load_line(1'b1, 1'b0);
        check_codes("R8 codes unchanged before latch", shown);
        latch();
        shown = tgt;
        check_codes("R2 8-bit dir low, R7 extra ignored", shown);
        frame_inv = 1'b1;
        @(negedge clk);
        check_codes("R9 frame high table", shown);
        frame_inv = 1'b0;

        // R6 then R3: 4-bit, dir low, enable held high for a while
        make_tgt(5);
        eio_a_in = 1'b1; eio_b_in = 1'b1;
        latch();
        shift(8'h0F); shift(8'h05); shift(8'h0A);
        check1("R6 no pulse while enable high", eio_a_out, 1'b1);
        eio_a_in = 1'b0; eio_b_in = 1'b0;
        load_line(1'b0, 1'b0);
        check_codes("R8 codes unchanged before latch (4-bit)", shown);
        latch();
        shown = tgt;
        check_codes("R3 4-bit dir low, R6 early edges ignored", shown);

        // R4: dir high, both widths
        make_tgt(11);
        latch();
        load_line(1'b1, 1'b1);
        latch();
        shown = tgt;
        check_codes("R4 8-bit dir high", shown);
        make_tgt(2);
        latch();
        load_line(1'b0, 1'b1);
        latch();
        shown = tgt;
        check_codes("R4 4-bit dir high", shown);

        // R10: display off, loading continues, deselect after release
        disp_on = 1'b0;
        repeat (3) @(negedge clk);
        check_codes("R10 display off lowest", shown);
        make_tgt(9);
        latch();
        load_line(1'b1, 1'b0);
        latch();
        check_codes("R10 still lowest while off", shown);
        disp_on = 1'b1;
        repeat (2) @(negedge clk);
        shown = '0;
        check_codes("R10 deselect after release frame low", shown);
        frame_inv = 1'b1;
        @(negedge clk);
        check_codes("R10 deselect after release frame high", shown);
        latch();
        shown = tgt;
        check_codes("R10 data loaded while off appears", shown);
        frame_inv = 1'b0;
        @(negedge clk);
        check_codes("R9 frame low table", shown);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule